// File: doc/BRIEF.md
# Dual-Word Load Execution Unit

This unit carries out the load-two-registers operation of a 32-bit processor. It receives an instruction that has already been split into fields. The fields are a format selector, the base and destination register numbers, the indexing, direction and writeback bits, and the raw immediate bits. Alongside them it receives the base register value, a condition-passed flag and the data endianness. From these it forms an effective address and reads two 32-bit words through a valid/ready request port. Each read returns with an acknowledge pulse. The unit then writes both words, and optionally the updated base, into the register file in a single cycle.

An access address on an 8-byte boundary is served by one 64-bit read, and the endianness flag decides which half goes to which register. Any other address takes two 32-bit reads, one after the other. Encodings the unit does not serve are refused: the PC-relative base form and one reserved mode combination. Register choices whose outcome the architecture leaves open are flagged, but they still execute.

Top module: `dword_load_unit`

## Requirements
- R1: With `fmt_sel`=0, the offset is `{imm_hi, imm_lo}` zero-extended (0..255), and `imm_word` is ignored. The second destination is `dst_a_idx`+1 modulo 16, and `dst_b_idx` is ignored.
- R2: With `fmt_sel`=1, the offset is `imm_word`×4 zero-extended (0..1020), and `imm_hi`/`imm_lo` are ignored. The second destination is `dst_b_idx`.
- R3: The offset address is `base_val`+offset when `up_sel`=1 and `base_val`−offset when `up_sel`=0. The reads start at the offset address when `pre_sel`=1 and at `base_val` when `pre_sel`=0.
- R4: Base writeback is enabled when (`fmt_sel`=0 and (`pre_sel`=0 or `wb_sel`=1)) or when (`fmt_sel`=1 and `wb_sel`=1). When enabled, `wr_base_en` writes the offset address to register `base_idx`.
- R5: An access address whose low three bits are zero gives exactly one request with `mem_req_wide`=1. With `big_end`=1, the first destination gets `mem_rdata[63:32]` and the second gets `mem_rdata[31:0]`. With `big_end`=0, the assignment is swapped.
- R6: Any other access address gives two requests with `mem_req_wide`=0: first at the address, then at the address+4. Each word is taken from `mem_rdata[31:0]`. The first word goes to the first destination and the second word to the second, whatever `big_end` is.
- R7: `base_idx`=15 sets `literal_form`. `fmt_sel`=1 with `pre_sel`=0 and `wb_sel`=0 sets `bad_encoding`. In both cases no request or register write takes place, and `unpredictable` stays 0.
- R8: `unpredictable` is 1 when any of these holds:
  - writeback is enabled and the base equals either destination;
  - the second destination is 15;
  - with `fmt_sel`=0, `dst_a_idx` is odd, or `pre_sel`=0 and `wb_sel`=1;
  - with `fmt_sel`=1, `dst_a_idx` is 15 or both destinations are equal.

  Such an instruction still performs its reads and writes.
- R9: With `cond_ok`=0, no request or register write takes place, and `done` still pulses.
- R10: A request is held with `mem_req_addr` and `mem_req_wide` unchanged until `mem_req_ready` is seen.
- R11: `wr_a_en`, `wr_b_en` and any `wr_base_en` are high together for one cycle, and `done` is high the next cycle. `ready_in` is high only when idle. `start` while busy is ignored, and the operands are captured at acceptance. The flags are held from acceptance until the next acceptance.
- R12: After reset, `ready_in`=1 and `mem_req_valid`, all write enables and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction offered; taken when `ready_in` is high |
| ready_in | output | 1 | Unit idle and able to take an instruction |
| fmt_sel | input | 1 | 0: byte-offset paired format, 1: word-scaled format |
| base_idx | input | 4 | Base register number |
| dst_a_idx | input | 4 | First destination register number |
| dst_b_idx | input | 4 | Second destination field (word-scaled format only) |
| pre_sel | input | 1 | 1: access at the offset address, 0: access at the base |
| up_sel | input | 1 | 1: add the offset, 0: subtract it |
| wb_sel | input | 1 | Writeback request bit |
| imm_hi | input | 4 | Upper nibble of the byte offset |
| imm_lo | input | 4 | Lower nibble of the byte offset |
| imm_word | input | 8 | Word-count offset |
| base_val | input | 32 | Base register value |
| cond_ok | input | 1 | Condition passed |
| big_end | input | 1 | Data is big-endian |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read address |
| mem_req_wide | output | 1 | 1: 64-bit read, 0: 32-bit read |
| mem_ack | input | 1 | Read data valid pulse |
| mem_rdata | input | 64 | Read data (32-bit reads use bits 31:0) |
| wr_a_en | output | 1 | First destination write |
| wr_a_idx | output | 4 | First destination number |
| wr_a_data | output | 32 | First destination data |
| wr_b_en | output | 1 | Second destination write |
| wr_b_idx | output | 4 | Second destination number |
| wr_b_data | output | 32 | Second destination data |
| wr_base_en | output | 1 | Base writeback |
| wr_base_idx | output | 4 | Base register number |
| wr_base_data | output | 32 | Updated base value |
| done | output | 1 | Instruction finished pulse |
| literal_form | output | 1 | Base was register 15; refused |
| bad_encoding | output | 1 | Reserved mode combination; refused |
| unpredictable | output | 1 | Register choice has an open outcome |

## Verification
The bench aims at several corner cases.

- Alignment: addresses on and off an 8-byte boundary. A unit that tested alignment on the base rather than on the access address would issue the wrong number of reads.
- Endianness: both settings, on single and split reads. Swapped halves show up only on a 64-bit read; split reads must ignore endianness.
- Offset scaling: maximum offsets added and subtracted, with post-indexing. An error in scaling or sign, or in choosing between base and offset address, lands on the wrong address or the wrong writeback value.
- Field ignoring: the unused destination and immediate fields are driven with conflicting values. A mixed-up pairing rule then writes the wrong register.
- Refused forms and a failed condition: any stray request or write is counted.
- Flags: every open-outcome case is covered.
- Busy and stall behaviour: new operands are offered while busy, and the request port is stalled. A unit that re-latched operands or dropped a held request would produce different addresses or data.

// File: rtl/dwl_pkg.sv
package dwl_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned RIDX_W  = 4;
    localparam int unsigned BEAT_W  = 2 * WORD_W;
    localparam int unsigned NIB_W   = 4;
    localparam int unsigned IMM8_W  = 8;
    localparam int unsigned WORD_SH = 2;
    localparam int unsigned PAIR_ALIGN_BYTES = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    localparam ridx_t PC_IDX = ridx_t'((1 << RIDX_W) - 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT1,
        ST_ISSUE2,
        ST_WAIT2,
        ST_COMMIT,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        addr_t offset;
        ridx_t base;
        ridx_t dst_a;
        ridx_t dst_b;
        logic  pre;
        logic  up;
        logic  wb;
        logic  literal;
        logic  reject;
        logic  unpred;
    } dec_t;

    typedef struct packed {
        addr_t acc;
        addr_t upd;
        logic  wide;
        ridx_t base;
        ridx_t dst_a;
        ridx_t dst_b;
        logic  wb;
        logic  big;
    } job_t;

    function automatic addr_t byte_offset(input logic [NIB_W-1:0] hi,
                                          input logic [NIB_W-1:0] lo);
        return addr_t'({hi, lo});
    endfunction

    function automatic addr_t word_offset(input logic [IMM8_W-1:0] cnt);
        return addr_t'(cnt) << WORD_SH;
    endfunction

endpackage

// File: rtl/dwl_decode.sv
module dwl_decode
    import dwl_pkg::*;
(
    input  logic              fmt_sel,
    input  ridx_t             base_idx,
    input  ridx_t             dst_a_idx,
    input  ridx_t             dst_b_field,
    input  logic              pre_sel,
    input  logic              up_sel,
    input  logic              wb_sel,
    input  logic [NIB_W-1:0]  imm_hi,
    input  logic [NIB_W-1:0]  imm_lo,
    input  logic [IMM8_W-1:0] imm_word,
    output dec_t              dec
);

    logic  wb_on;
    ridx_t second;
    logic  overlap;
    logic  fmt0_bad;
    logic  fmt1_bad;

    always_comb begin
        second  = fmt_sel ? dst_b_field : ridx_t'(dst_a_idx + ridx_t'(1));
        wb_on   = fmt_sel ? wb_sel : (!pre_sel || wb_sel);
        overlap = wb_on && ((base_idx == dst_a_idx) || (base_idx == second));
        fmt0_bad = !fmt_sel && (dst_a_idx[0] || (!pre_sel && wb_sel));
        fmt1_bad = fmt_sel && ((dst_a_idx == PC_IDX) || (dst_a_idx == second));

        dec.offset  = fmt_sel ? word_offset(imm_word) : byte_offset(imm_hi, imm_lo);
        dec.base    = base_idx;
        dec.dst_a   = dst_a_idx;
        dec.dst_b   = second;
        dec.pre     = pre_sel;
        dec.up      = up_sel;
        dec.wb      = wb_on;
        dec.literal = (base_idx == PC_IDX);
        dec.reject  = fmt_sel && !pre_sel && !wb_sel;
        dec.unpred  = (overlap || (second == PC_IDX) || fmt0_bad || fmt1_bad)
                      && !dec.literal && !dec.reject;
    end

endmodule

// File: rtl/dwl_agen.sv
module dwl_agen
    import dwl_pkg::*;
#(
    parameter int unsigned ALIGN_BYTES = PAIR_ALIGN_BYTES
) (
    input  addr_t base_val,
    input  addr_t offset,
    input  logic  up,
    input  logic  pre,
    output addr_t upd_addr,
    output addr_t acc_addr,
    output logic  aligned
);

    localparam int unsigned ALIGN_LSB = $clog2(ALIGN_BYTES);

    always_comb begin
        upd_addr = up ? (base_val + offset) : (base_val - offset);
        acc_addr = pre ? upd_addr : base_val;
    end

    generate
        if (ALIGN_LSB == 0) begin : g_no_align
            assign aligned = 1'b1;
        end else begin : g_align
            assign aligned = (acc_addr[ALIGN_LSB-1:0] == '0);
        end
    endgenerate

endmodule

// File: rtl/dwl_seq.sv
module dwl_seq
    import dwl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              ready_in,
    input  dec_t              dec,
    input  addr_t             acc_addr,
    input  addr_t             upd_addr,
    input  logic              aligned,
    input  logic              cond_ok,
    input  logic              big_end,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output addr_t             mem_req_addr,
    output logic              mem_req_wide,
    input  logic              mem_ack,
    input  logic [BEAT_W-1:0] mem_rdata,
    output logic              wr_a_en,
    output ridx_t             wr_a_idx,
    output word_t             wr_a_data,
    output logic              wr_b_en,
    output ridx_t             wr_b_idx,
    output word_t             wr_b_data,
    output logic              wr_base_en,
    output ridx_t             wr_base_idx,
    output addr_t             wr_base_data,
    output logic              done,
    output logic              literal_form,
    output logic              bad_encoding,
    output logic              unpredictable
);

    localparam addr_t WORD_BYTES = addr_t'(WORD_W / 8);

    seq_state_e state;
    job_t       job;
    word_t      data_a;
    word_t      data_b;
    logic       skip;

    assign skip = !cond_ok || dec.literal || dec.reject;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            job           <= '0;
            data_a        <= '0;
            data_b        <= '0;
            literal_form  <= 1'b0;
            bad_encoding  <= 1'b0;
            unpredictable <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        job.acc       <= acc_addr;
                        job.upd       <= upd_addr;
                        job.wide      <= aligned;
                        job.base      <= dec.base;
                        job.dst_a     <= dec.dst_a;
                        job.dst_b     <= dec.dst_b;
                        job.wb        <= dec.wb;
                        job.big       <= big_end;
                        literal_form  <= dec.literal;
                        bad_encoding  <= dec.reject;
                        unpredictable <= dec.unpred;
                        state         <= skip ? ST_FINISH : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) state <= ST_WAIT1;
                end
                ST_WAIT1: begin
                    if (mem_ack) begin
                        if (job.wide) begin
                            if (job.big) begin
                                data_a <= mem_rdata[BEAT_W-1:WORD_W];
                                data_b <= mem_rdata[WORD_W-1:0];
                            end else begin
                                data_a <= mem_rdata[WORD_W-1:0];
                                data_b <= mem_rdata[BEAT_W-1:WORD_W];
                            end
                            state <= ST_COMMIT;
                        end else begin
                            data_a <= mem_rdata[WORD_W-1:0];
                            state  <= ST_ISSUE2;
                        end
                    end
                end
                ST_ISSUE2: begin
                    if (mem_req_ready) state <= ST_WAIT2;
                end
                ST_WAIT2: begin
                    if (mem_ack) begin
                        data_b <= mem_rdata[WORD_W-1:0];
                        state  <= ST_COMMIT;
                    end
                end
                ST_COMMIT: state <= ST_FINISH;
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ready_in      = (state == ST_IDLE);
        mem_req_valid = (state == ST_ISSUE) || (state == ST_ISSUE2);
        mem_req_wide  = (state == ST_ISSUE) && job.wide;
        mem_req_addr  = (state == ST_ISSUE2) ? (job.acc + WORD_BYTES) : job.acc;
        wr_a_en       = (state == ST_COMMIT);
        wr_b_en       = (state == ST_COMMIT);
        wr_base_en    = (state == ST_COMMIT) && job.wb;
        wr_a_idx      = job.dst_a;
        wr_b_idx      = job.dst_b;
        wr_base_idx   = job.base;
        wr_a_data     = data_a;
        wr_b_data     = data_b;
        wr_base_data  = job.upd;
        done          = (state == ST_FINISH);
    end

    p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wide)));

    p_wide_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_wide) |-> (mem_req_addr[2:0] == 3'b000));

    p_no_accept_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !ready_in);

endmodule

// File: rtl/dword_load_unit.sv
module dword_load_unit
    import dwl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    output logic         ready_in,
    input  logic         fmt_sel,
    input  logic [3:0]   base_idx,
    input  logic [3:0]   dst_a_idx,
    input  logic [3:0]   dst_b_idx,
    input  logic         pre_sel,
    input  logic         up_sel,
    input  logic         wb_sel,
    input  logic [3:0]   imm_hi,
    input  logic [3:0]   imm_lo,
    input  logic [7:0]   imm_word,
    input  logic [31:0]  base_val,
    input  logic         cond_ok,
    input  logic         big_end,
    output logic         mem_req_valid,
    input  logic         mem_req_ready,
    output logic [31:0]  mem_req_addr,
    output logic         mem_req_wide,
    input  logic         mem_ack,
    input  logic [63:0]  mem_rdata,
    output logic         wr_a_en,
    output logic [3:0]   wr_a_idx,
    output logic [31:0]  wr_a_data,
    output logic         wr_b_en,
    output logic [3:0]   wr_b_idx,
    output logic [31:0]  wr_b_data,
    output logic         wr_base_en,
    output logic [3:0]   wr_base_idx,
    output logic [31:0]  wr_base_data,
    output logic         done,
    output logic         literal_form,
    output logic         bad_encoding,
    output logic         unpredictable
);

    dec_t  dec;
    addr_t upd_addr;
    addr_t acc_addr;
    logic  aligned;

    dwl_decode u_decode (
        .fmt_sel     (fmt_sel),
        .base_idx    (base_idx),
        .dst_a_idx   (dst_a_idx),
        .dst_b_field (dst_b_idx),
        .pre_sel     (pre_sel),
        .up_sel      (up_sel),
        .wb_sel      (wb_sel),
        .imm_hi      (imm_hi),
        .imm_lo      (imm_lo),
        .imm_word    (imm_word),
        .dec         (dec)
    );

    dwl_agen #(.ALIGN_BYTES(PAIR_ALIGN_BYTES)) u_agen (
        .base_val (base_val),
        .offset   (dec.offset),
        .up       (dec.up),
        .pre      (dec.pre),
        .upd_addr (upd_addr),
        .acc_addr (acc_addr),
        .aligned  (aligned)
    );

    dwl_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .ready_in      (ready_in),
        .dec           (dec),
        .acc_addr      (acc_addr),
        .upd_addr      (upd_addr),
        .aligned       (aligned),
        .cond_ok       (cond_ok),
        .big_end       (big_end),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wide  (mem_req_wide),
        .mem_ack       (mem_ack),
        .mem_rdata     (mem_rdata),
        .wr_a_en       (wr_a_en),
        .wr_a_idx      (wr_a_idx),
        .wr_a_data     (wr_a_data),
        .wr_b_en       (wr_b_en),
        .wr_b_idx      (wr_b_idx),
        .wr_b_data     (wr_b_data),
        .wr_base_en    (wr_base_en),
        .wr_base_idx   (wr_base_idx),
        .wr_base_data  (wr_base_data),
        .done          (done),
        .literal_form  (literal_form),
        .bad_encoding  (bad_encoding),
        .unpredictable (unpredictable)
    );

    p_wb_with_regs_r4: assert property (@(posedge clk) disable iff (rst)
        wr_base_en |-> (wr_a_en && wr_b_en));

    p_done_follows_r11: assert property (@(posedge clk) disable iff (rst)
        wr_a_en |=> (done && !wr_a_en && !wr_b_en));

    p_refused_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (done && (literal_form || bad_encoding)) |-> !unpredictable);

endmodule

// File: tb/dword_load_unit_test.sv
module dword_load_unit_test;

    typedef struct packed {
        logic        fmt;
        logic [3:0]  bn;
        logic [3:0]  da;
        logic [3:0]  db;
        logic        p;
        logic        u;
        logic        w;
        logic [7:0]  imm;
        logic [31:0] bv;
        logic        cond;
        logic        big;
        logic [1:0]  nreq;
        logic [31:0] addr;
        logic        wb;
        logic [31:0] wbv;
        logic        unp;
        logic        lit;
        logic        rej;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd2,  4'd4,  4'd9, 1'b1, 1'b1, 1'b0, 8'h10, 32'h1000, 1'b1, 1'b0, 2'd1, 32'h1010, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd2,  4'd4,  4'd9, 1'b1, 1'b1, 1'b0, 8'h10, 32'h1000, 1'b1, 1'b1, 2'd1, 32'h1010, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd3,  4'd6,  4'd0, 1'b1, 1'b0, 1'b1, 8'h24, 32'h2000, 1'b1, 1'b1, 2'd2, 32'h1FDC, 1'b1, 32'h1FDC, 1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd1,  4'd8,  4'd2, 1'b0, 1'b1, 1'b0, 8'h08, 32'h3004, 1'b1, 1'b0, 2'd2, 32'h3004, 1'b1, 32'h300C, 1'b0, 1'b0, 1'b0},
        '{1'b1, 4'd5,  4'd0,  4'd7, 1'b1, 1'b1, 1'b0, 8'h03, 32'h4004, 1'b1, 1'b1, 2'd1, 32'h4010, 1'b0, 32'h0,    1'b0, 1'b0, 1'b0},
        '{1'b1, 4'd6,  4'd2,  4'd3, 1'b0, 1'b0, 1'b1, 8'hFF, 32'h8000, 1'b1, 1'b0, 2'd1, 32'h8000, 1'b1, 32'h7C04, 1'b0, 1'b0, 1'b0},
        '{1'b1, 4'd9,  4'd10, 4'd1, 1'b1, 1'b1, 1'b1, 8'hFF, 32'h0100, 1'b1, 1'b0, 2'd2, 32'h04FC, 1'b1, 32'h04FC, 1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd7,  4'd3,  4'd0, 1'b1, 1'b1, 1'b0, 8'h00, 32'h5000, 1'b1, 1'b0, 2'd1, 32'h5000, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0},
        '{1'b0, 4'd4,  4'd4,  4'd0, 1'b1, 1'b1, 1'b1, 8'h08, 32'h6000, 1'b1, 1'b0, 2'd1, 32'h6008, 1'b1, 32'h6008, 1'b1, 1'b0, 1'b0},
        '{1'b0, 4'd0,  4'd14, 4'd0, 1'b1, 1'b1, 1'b0, 8'h00, 32'h7000, 1'b1, 1'b0, 2'd1, 32'h7000, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0},
        '{1'b0, 4'd2,  4'd0,  4'd0, 1'b0, 1'b1, 1'b1, 8'h04, 32'h9000, 1'b1, 1'b0, 2'd1, 32'h9000, 1'b1, 32'h9004, 1'b1, 1'b0, 1'b0},
        '{1'b1, 4'd1,  4'd5,  4'd5, 1'b1, 1'b1, 1'b0, 8'h01, 32'hA000, 1'b1, 1'b0, 2'd2, 32'hA004, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0},
        '{1'b1, 4'd2,  4'd15, 4'd3, 1'b1, 1'b1, 1'b0, 8'h02, 32'hB000, 1'b1, 1'b0, 2'd1, 32'hB008, 1'b0, 32'h0,    1'b1, 1'b0, 1'b0},
        '{1'b0, 4'd15, 4'd4,  4'd0, 1'b1, 1'b1, 1'b0, 8'h00, 32'hC000, 1'b1, 1'b0, 2'd0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b1, 1'b0},
        '{1'b1, 4'd3,  4'd4,  4'd5, 1'b0, 1'b1, 1'b0, 8'h01, 32'hD000, 1'b1, 1'b0, 2'd0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b1},
        '{1'b0, 4'd2,  4'd4,  4'd0, 1'b1, 1'b1, 1'b0, 8'h10, 32'h1000, 1'b0, 1'b0, 2'd0, 32'h0,    1'b0, 32'h0,    1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        ready_in;
    logic        fmt_sel = 1'b0;
    logic [3:0]  base_idx = '0, dst_a_idx = '0, dst_b_idx = '0;
    logic        pre_sel = 1'b0, up_sel = 1'b0, wb_sel = 1'b0;
    logic [3:0]  imm_hi = '0, imm_lo = '0;
    logic [7:0]  imm_word = '0;
    logic [31:0] base_val = '0;
    logic        cond_ok = 1'b0, big_end = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_req_wide;
    logic        mem_ack;
    logic [63:0] mem_rdata;
    logic        wr_a_en, wr_b_en, wr_base_en;
    logic [3:0]  wr_a_idx, wr_b_idx, wr_base_idx;
    logic [31:0] wr_a_data, wr_b_data, wr_base_data;
    logic        done, literal_form, bad_encoding, unpredictable;

    int n_chk = 0;
    int n_bad = 0;

    int          req_n;
    logic [31:0] req_addr [2];
    logic        req_wide [2];
    logic        stall_mode = 1'b0;

    always #10 clk = ~clk;

    dword_load_unit uut (.*);

    function automatic logic [31:0] memword(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: ack one cycle after handshake
    initial begin
        logic        pend;
        logic [31:0] pa;
        logic        pw;
        pend = 1'b0; pa = '0; pw = 1'b0;
        mem_ack = 1'b0; mem_rdata = '0; mem_req_ready = 1'b1;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (pend) begin
                mem_ack = 1'b1;
                mem_rdata = pw ? {memword(pa + 32'd4), memword(pa)}
                               : {~memword(pa), memword(pa)};
                pend = 1'b0;
            end
            mem_req_ready = stall_mode ? ~mem_req_ready : 1'b1;
            if (mem_req_valid && mem_req_ready) begin
                pend = 1'b1; pa = mem_req_addr; pw = mem_req_wide;
                if (req_n < 2) begin
                    req_addr[req_n] = mem_req_addr;
                    req_wide[req_n] = mem_req_wide;
                end
                req_n++;
            end
        end
    end

    task automatic drive(input vec_t v);
        fmt_sel   = v.fmt;
        base_idx  = v.bn;
        dst_a_idx = v.da;
        dst_b_idx = v.db;
        pre_sel   = v.p;
        up_sel    = v.u;
        wb_sel    = v.w;
        imm_hi    = v.fmt ? ~v.imm[7:4] : v.imm[7:4];
        imm_lo    = v.fmt ? ~v.imm[3:0] : v.imm[3:0];
        imm_word  = v.fmt ? v.imm : ~v.imm;
        base_val  = v.bv;
        cond_ok   = v.cond;
        big_end   = v.big;
    endtask

    task automatic run(input vec_t v, input bit busy_noise, input vec_t noise);
        int          wr_n;
        logic [31:0] a_d, b_d, wbd;
        logic [3:0]  a_i, b_i, wbi;
        logic        wbe, fl_u, fl_l, fl_r;
        logic [31:0] ea, eb;
        logic [3:0]  eb_i;
        int          cyc;
        wr_n = 0; a_d = '0; b_d = '0; wbd = '0; a_i = '0; b_i = '0; wbi = '0;
        wbe = 1'b0; fl_u = 1'b0; fl_l = 1'b0; fl_r = 1'b0;
        @(negedge clk);
        req_n = 0;
        drive(v);
        start = 1'b1;
        @(negedge clk);
        if (busy_noise) drive(noise); else start = 1'b0;
        for (cyc = 0; cyc < 500; cyc++) begin
            if (wr_a_en) begin
                wr_n++;
                a_d = wr_a_data; a_i = wr_a_idx;
                b_d = wr_b_data; b_i = wr_b_idx;
                wbe = wr_base_en; wbd = wr_base_data; wbi = wr_base_idx;
            end
            if (done) begin
                fl_u = unpredictable; fl_l = literal_form; fl_r = bad_encoding;
                start = 1'b0;
                break;
            end
            @(negedge clk);
        end
        if (cyc >= 500) chk("R11", "done timeout", 32'd0, 32'd1);
        chk("R9", "request count", req_n, {30'd0, v.nreq});
        chk("R9", "write count", wr_n, (v.nreq != 0) ? 1 : 0);
        chk("R8", "unpredictable", {31'd0, fl_u}, {31'd0, v.unp});
        chk("R7", "literal_form", {31'd0, fl_l}, {31'd0, v.lit});
        chk("R7", "bad_encoding", {31'd0, fl_r}, {31'd0, v.rej});
        if (v.nreq != 0) begin
            chk("R3", "first address", req_addr[0], v.addr);
            chk("R5", "first size", {31'd0, req_wide[0]}, (v.nreq == 1) ? 1 : 0);
            if (v.nreq == 2) begin
                chk("R6", "second address", req_addr[1], v.addr + 32'd4);
                chk("R6", "second size", {31'd0, req_wide[1]}, 32'd0);
            end
            if (v.nreq == 1 && v.big) begin
                ea = memword(v.addr + 32'd4); eb = memword(v.addr);
            end else begin
                ea = memword(v.addr); eb = memword(v.addr + 32'd4);
            end
            eb_i = v.fmt ? v.db : v.da + 4'd1;
            chk("R5", "first data", a_d, ea);
            chk("R6", "second data", b_d, eb);
            chk("R1", "first index", {28'd0, a_i}, {28'd0, v.da});
            chk("R2", "second index", {28'd0, b_i}, {28'd0, eb_i});
            chk("R4", "writeback enable", {31'd0, wbe}, {31'd0, v.wb});
            if (v.wb) begin
                chk("R4", "writeback value", wbd, v.wbv);
                chk("R4", "writeback index", {28'd0, wbi}, {28'd0, v.bn});
            end
        end
        @(negedge clk);
        chk("R11", "idle after done", {31'd0, ready_in}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        req_n = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12", "ready_in", {31'd0, ready_in}, 32'd1);
        chk("R12", "mem_req_valid", {31'd0, mem_req_valid}, 32'd0);
        chk("R12", "write enables", {29'd0, wr_a_en, wr_b_en, wr_base_en}, 32'd0);
        chk("R12", "done", {31'd0, done}, 32'd0);

        for (int i = 0; i < NV; i++) run(VECS[i], 1'b0, VECS[0]);

        // R11: start held with new operands while busy is ignored
        run(VECS[2], 1'b1, VECS[5]);
        // R10: stalled request port, request must be held
        stall_mode = 1'b1;
        run(VECS[6], 1'b0, VECS[0]);
        run(VECS[1], 1'b1, VECS[3]);
        stall_mode = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule